// File: doc/BRIEF.md
# Conjugate-Sum Image Cancelling Combiner

This block removes the mirror image of a strong out-of-band signal from a decimated complex baseband stream. It has two sample-aligned complex inputs. Stream A comes from a downconverter tuned to the wanted band. Stream B comes from a second downconverter tuned to the sample rate minus the first tuning frequency, so B carries the blocker that folds into A. Each stream passes through its own 16-tap complex FIR. Filter A equalises the Q path against the I path so the wanted band stays flat. Filter B shapes the blocker into an anti-image. The output is the filter A result plus the complex conjugate of the filter B result. Conjugation reverses frequency, so the anti-image lines up with the image and cancels it.

The filters run at the decimated rate, so a given tap count covers a longer span of mismatch than it would at the full sample rate. Coefficients are signed fixed point and are written one tap at a time through an address/data port. The sum is scaled down by a fixed arithmetic shift and saturated to the output width.

Top module: `conj_image_combiner`

## Requirements
- R1: While rst_n is low at a rising edge, out_valid is low and out_re and out_im are zero after that edge.
- R2: A sample pair is accepted only on a rising edge where a_valid and b_valid are both high. An edge with only one of them high produces no output and does not enter either filter's history.
- R3: For accepted sample n, filter A computes real = sum over k of (har[k]·xar[n−k] − hai[k]·xai[n−k]) and imaginary = sum over k of (har[k]·xai[n−k] + hai[k]·xar[n−k]), for k = 0..15. Tap 0 multiplies the newest sample, and only the 16 most recent accepted samples contribute.
- R4: Filter B uses the same formula on stream B. The combined value is real = A_re + B_re and imaginary = A_im − B_im, which means the conjugate of B is added to A.
- R5: Each combined component is shifted right arithmetically by SHIFT bits (default 15, rounding toward minus infinity) before it leaves the block.
- R6: Each shifted component saturates to the signed OW-bit range: 32767 and −32768 for the default OW = 16.
- R7: Each accepted pair produces exactly one output. out_valid is high in the cycle after the third rising edge counted from the accepting edge, and the outputs hold their last value while out_valid is low.
- R8: Reset clears all coefficients to zero. A write with cf_we high on a rising edge stores cf_re and cf_im as tap cf_addr of filter A when cf_sel = 0, or of filter B when cf_sel = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_valid | input | 1 | Wanted-band sample valid |
| a_re | input | 16 | Wanted-band real part |
| a_im | input | 16 | Wanted-band imaginary part |
| b_valid | input | 1 | Blocker-band sample valid |
| b_re | input | 16 | Blocker-band real part |
| b_im | input | 16 | Blocker-band imaginary part |
| cf_we | input | 1 | Coefficient write strobe |
| cf_sel | input | 1 | Filter select: 0 = A, 1 = B |
| cf_addr | input | 4 | Tap index |
| cf_re | input | 16 | Coefficient real part |
| cf_im | input | 16 | Coefficient imaginary part |
| out_valid | output | 1 | Output sample valid |
| out_re | output | 16 | Output real part |
| out_im | output | 16 | Output imaginary part |

## Verification
A corrupted delay-line entry or a wrong coefficient does not show at once. It appears as wrong output values only when that tap lines up with a nonzero coefficient. This can take up to 16 accepted samples, so the bench uses long random streams with all taps active and compares every output. A sign slip in the conjugation changes only the imaginary part, and only when filter B is active. A lost or extra valid pulse shows on the very next output, as a latency error or a count mismatch. The directed cases cover saturation in both directions and floor rounding of small negative values.

// File: rtl/cic_pkg.sv
// Shared sizing for the conjugate-sum combiner.
// Assumes: all arithmetic is two's complement.
package cic_pkg;
    // Width of a complex FIR accumulator for the given operand widths and taps.
    function automatic int acc_width(input int dw, input int cw, input int taps);
        return dw + cw + 1 + $clog2(taps);
    endfunction
endpackage

// File: rtl/cic_cfir.sv
// Complex FIR: coefficient bank, sample history and a full-precision sum.
// Assumes: in_vld marks an accepted sample. Tap 0 weights the newest sample.
// Latency: the sum of the new history is registered one edge after acceptance.
module cic_cfir #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int TAPS = 16,
    parameter int AW   = $clog2(TAPS),
    parameter int ACCW = cic_pkg::acc_width(DW, CW, TAPS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic signed [DW-1:0]   x_re,
    input  logic signed [DW-1:0]   x_im,
    input  logic                   we,
    input  logic        [AW-1:0]   addr,
    input  logic signed [CW-1:0]   c_re,
    input  logic signed [CW-1:0]   c_im,
    output logic                   y_vld,
    output logic signed [ACCW-1:0] y_re,
    output logic signed [ACCW-1:0] y_im
);
    logic signed [DW-1:0]   xr_q [TAPS];
    logic signed [DW-1:0]   xi_q [TAPS];
    logic signed [CW-1:0]   hr_q [TAPS];
    logic signed [CW-1:0]   hi_q [TAPS];
    logic                   hist_vld_q;
    logic signed [ACCW-1:0] sum_re, sum_im;

    // Coefficient bank: cleared on reset, one tap written per strobe.
    always_ff @(posedge clk) begin
        for (int k = 0; k < TAPS; k++) begin
            if (!rst_n) begin
                hr_q[k] <= '0;
                hi_q[k] <= '0;
            end else if (we && addr == AW'(k)) begin
                hr_q[k] <= c_re;
                hi_q[k] <= c_im;
            end
        end
    end

    // Sample history: shifts one place per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) begin
                xr_q[k] <= '0;
                xi_q[k] <= '0;
            end
        end else if (in_vld) begin
            xr_q[0] <= x_re;
            xi_q[0] <= x_im;
            for (int k = 1; k < TAPS; k++) begin
                xr_q[k] <= xr_q[k-1];
                xi_q[k] <= xi_q[k-1];
            end
        end
    end

    // Complex multiply-accumulate over every tap at full precision.
    always_comb begin
        sum_re = '0;
        sum_im = '0;
        for (int k = 0; k < TAPS; k++) begin
            sum_re = sum_re + ACCW'(hr_q[k]) * ACCW'(xr_q[k])
                            - ACCW'(hi_q[k]) * ACCW'(xi_q[k]);
            sum_im = sum_im + ACCW'(hr_q[k]) * ACCW'(xi_q[k])
                            + ACCW'(hi_q[k]) * ACCW'(xr_q[k]);
        end
    end

    // Result register: captures the sum one edge after a history update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_vld_q <= 1'b0;
            y_vld      <= 1'b0;
            y_re       <= '0;
            y_im       <= '0;
        end else begin
            hist_vld_q <= in_vld;
            y_vld      <= hist_vld_q;
            if (hist_vld_q) begin
                y_re <= sum_re;
                y_im <= sum_im;
            end
        end
    end
endmodule

// File: rtl/cic_conj_sum.sv
// Adds filter A to the conjugate of filter B, then shifts and saturates.
// Assumes: both filter results are valid in the same cycle.
module cic_conj_sum #(
    parameter int ACCW  = 37,
    parameter int OW    = 16,
    parameter int SHIFT = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   vld,
    input  logic signed [ACCW-1:0] a_re,
    input  logic signed [ACCW-1:0] a_im,
    input  logic signed [ACCW-1:0] b_re,
    input  logic signed [ACCW-1:0] b_im,
    output logic                   o_vld,
    output logic signed [OW-1:0]   o_re,
    output logic signed [OW-1:0]   o_im
);
    localparam int SW = ACCW + 1;
    localparam logic signed [SW-1:0] HI = (SW'(1) <<< (OW - 1)) - SW'(1);
    localparam logic signed [SW-1:0] LO = -HI - SW'(1);

    logic signed [SW-1:0] s_re, s_im, sh_re, sh_im;
    logic signed [OW-1:0] q_re, q_im;

    // Conjugate sum and scaling: the imaginary part of B is negated.
    always_comb begin
        s_re  = SW'(a_re) + SW'(b_re);
        s_im  = SW'(a_im) - SW'(b_im);
        sh_re = s_re >>> SHIFT;
        sh_im = s_im >>> SHIFT;
    end

    // Saturation to the output range.
    always_comb begin
        if (sh_re > HI)      q_re = OW'(HI);
        else if (sh_re < LO) q_re = OW'(LO);
        else                 q_re = OW'(sh_re);
        if (sh_im > HI)      q_im = OW'(HI);
        else if (sh_im < LO) q_im = OW'(LO);
        else                 q_im = OW'(sh_im);
    end

    // Output register: updates only with a valid sum, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld <= 1'b0;
            o_re  <= '0;
            o_im  <= '0;
        end else begin
            o_vld <= vld;
            if (vld) begin
                o_re <= q_re;
                o_im <= q_im;
            end
        end
    end
endmodule

// File: rtl/conj_image_combiner.sv
// Image cancelling combiner: two complex FIRs and a conjugate-sum stage.
// Assumes: streams A and B are sample-aligned. A pair is taken only when both
// valids are high. Coefficients should be loaded while no samples are in flight.
module conj_image_combiner #(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int TAPS  = 16,
    parameter int OW    = 16,
    parameter int SHIFT = 15,
    parameter int AW    = $clog2(TAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 a_valid,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic                 b_valid,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic                 cf_we,
    input  logic                 cf_sel,
    input  logic        [AW-1:0] cf_addr,
    input  logic signed [CW-1:0] cf_re,
    input  logic signed [CW-1:0] cf_im,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_re,
    output logic signed [OW-1:0] out_im
);
    localparam int ACCW = cic_pkg::acc_width(DW, CW, TAPS);

    logic                   take;
    logic [1:0]             we_f;
    logic [1:0]             yv;
    logic signed [ACCW-1:0] yr [2];
    logic signed [ACCW-1:0] yi [2];
    logic signed [DW-1:0]   xr [2];
    logic signed [DW-1:0]   xi [2];

    // Pair acceptance and per-filter write decode.
    always_comb begin
        take    = a_valid && b_valid;
        we_f[0] = cf_we && !cf_sel;
        we_f[1] = cf_we &&  cf_sel;
        xr[0] = a_re; xi[0] = a_im;
        xr[1] = b_re; xi[1] = b_im;
    end

    for (genvar f = 0; f < 2; f++) begin : g_fir
        cic_cfir #(.DW(DW), .CW(CW), .TAPS(TAPS), .AW(AW), .ACCW(ACCW)) u_fir (
            .clk(clk), .rst_n(rst_n), .in_vld(take),
            .x_re(xr[f]), .x_im(xi[f]),
            .we(we_f[f]), .addr(cf_addr), .c_re(cf_re), .c_im(cf_im),
            .y_vld(yv[f]), .y_re(yr[f]), .y_im(yi[f])
        );
    end

    cic_conj_sum #(.ACCW(ACCW), .OW(OW), .SHIFT(SHIFT)) u_sum (
        .clk(clk), .rst_n(rst_n), .vld(yv[0] && yv[1]),
        .a_re(yr[0]), .a_im(yi[0]), .b_re(yr[1]), .b_im(yi[1]),
        .o_vld(out_valid), .o_re(out_re), .o_im(out_im)
    );
endmodule

// File: rtl/cic_chk.sv
// Property checker for the combiner, attached to every instance by bind.
module cic_chk #(
    parameter int OW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_valid,
    input logic          b_valid,
    input logic          cf_we,
    input logic          out_valid,
    input logic [OW-1:0] out_re,
    input logic [OW-1:0] out_im
);
    logic seen_we;

    // Records whether any coefficient write happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     seen_we <= 1'b0;
        else if (cf_we) seen_we <= 1'b1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_re == '0 && out_im == '0));

    a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == ($past(a_valid && b_valid, 3) && $past(rst_n, 3)
                      && $past(rst_n, 2) && $past(rst_n, 1)));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_re) && $stable(out_im)));

    a_r8_zero_coef: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !seen_we) |-> (out_re == '0 && out_im == '0));
endmodule

bind conj_image_combiner cic_chk #(.OW(OW)) u_cic_chk (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .b_valid(b_valid),
    .cf_we(cf_we), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/conj_image_combiner_bench.sv
// Bench: directed corners plus seeded random streams, checked against a model.
module conj_image_combiner_bench;
    localparam int T = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_valid = 0, b_valid = 0, cf_we = 0, cf_sel = 0;
    logic signed [15:0] a_re = 0, a_im = 0, b_re = 0, b_im = 0, cf_re = 0, cf_im = 0;
    logic [3:0] cf_addr = 0;
    logic out_valid;
    logic signed [15:0] out_re, out_im;

    always #2.5 clk = ~clk;

    conj_image_combiner u_conj_image_combiner (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_re(a_re), .a_im(a_im),
        .b_valid(b_valid), .b_re(b_re), .b_im(b_im),
        .cf_we(cf_we), .cf_sel(cf_sel), .cf_addr(cf_addr), .cf_re(cf_re), .cf_im(cf_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    int total = 0, bad = 0;
    int cyc = 0;
    bit done = 0;
    string tag = "R1";

    longint h_r[2][T], h_i[2][T], x_r[2][T], x_i[2][T];
    longint q_re[$], q_im[$];
    int     q_cyc[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat16(input longint v);
        longint s = v >>> 15;
        if (s > 32767) return 32767;
        if (s < -32768) return -32768;
        return s;
    endfunction

    // Model step for an accepted pair: update history, queue expected output.
    task automatic model_push(input longint ar, ai, br, bi);
        longint fr[2], fi[2];
        for (int f = 0; f < 2; f++) begin
            for (int k = T - 1; k > 0; k--) begin
                x_r[f][k] = x_r[f][k-1];
                x_i[f][k] = x_i[f][k-1];
            end
        end
        x_r[0][0] = ar; x_i[0][0] = ai; x_r[1][0] = br; x_i[1][0] = bi;
        for (int f = 0; f < 2; f++) begin
            fr[f] = 0; fi[f] = 0;
            for (int k = 0; k < T; k++) begin
                fr[f] += h_r[f][k] * x_r[f][k] - h_i[f][k] * x_i[f][k];
                fi[f] += h_r[f][k] * x_i[f][k] + h_i[f][k] * x_r[f][k];
            end
        end
        q_re.push_back(sat16(fr[0] + fr[1]));
        q_im.push_back(sat16(fi[0] - fi[1]));
        q_cyc.push_back(cyc);
    endtask

    // Output monitor: compares every valid output against the model queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_re.size() == 0) begin
                chk("R2", 1, 0, "unexpected output count");
            end else begin
                chk(tag, out_re, q_re.pop_front(), "out_re");
                chk(tag, out_im, q_im.pop_front(), "out_im");
                chk("R7", cyc - q_cyc.pop_front(), 3, "latency");
            end
        end
    end

    task automatic drive(input bit av, bv, input longint ar, ai, br, bi);
        @(negedge clk);
        a_valid = av; b_valid = bv;
        a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
        if (av && bv) model_push(ar, ai, br, bi);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
    endtask

    task automatic load(input int f, input int k, input longint cr, ci);
        @(negedge clk);
        a_valid = 0; b_valid = 0;
        cf_we = 1; cf_sel = f[0]; cf_addr = 4'(k); cf_re = 16'(cr); cf_im = 16'(ci);
        h_r[f][k] = cr; h_i[f][k] = ci;
        @(negedge clk);
        cf_we = 0;
    endtask

    task automatic clear_coefs();
        for (int f = 0; f < 2; f++)
            for (int k = 0; k < T; k++) load(f, k, 0, 0);
    endtask

    function automatic longint rnd16();
        return longint'($signed(16'($urandom)));
    endfunction

    task automatic drain_check();
        idle(5);
        chk("R7", q_re.size(), 0, "outputs missing");
    endtask

    initial begin
        int seen;
        void'($urandom(32'd7351));
        for (int f = 0; f < 2; f++)
            for (int k = 0; k < T; k++) begin
                h_r[f][k] = 0; h_i[f][k] = 0; x_r[f][k] = 0; x_i[f][k] = 0;
            end
        a_valid = 1; b_valid = 1; a_re = 1234; b_re = -99;
        repeat (4) @(posedge clk);
        @(negedge clk);
        tag = "R1";
        chk("R1", out_valid, 0, "out_valid in reset");
        chk("R1", out_re, 0, "out_re in reset");
        chk("R1", out_im, 0, "out_im in reset");
        a_valid = 0; b_valid = 0; a_re = 0; b_re = 0;
        rst_n = 1;

        // R8: coefficients come out of reset as zero.
        tag = "R8";
        for (int i = 0; i < 6; i++) drive(1, 1, rnd16(), rnd16(), rnd16(), rnd16());
        drain_check();

        // R3: filter A alone, single and multi tap.
        tag = "R3";
        load(0, 0, 32767, 0);
        load(0, 5, -12000, 9000);
        for (int i = 0; i < 24; i++) drive(1, 1, rnd16(), rnd16(), rnd16(), rnd16());
        drain_check();

        // R4: filter B alone exercises the conjugate path.
        tag = "R4";
        clear_coefs();
        load(1, 3, 3000, 20000);
        load(1, 0, -16384, 0);
        for (int i = 0; i < 24; i++) drive(1, 1, rnd16(), rnd16(), rnd16(), rnd16());
        drain_check();

        // R2: one-sided valids are ignored; no output appears for them.
        tag = "R2";
        seen = 0;
        for (int i = 0; i < 8; i++) drive(i % 2 == 0, i % 2 == 1, 30000, -30000, 25000, 111);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        chk("R2", seen, 0, "outputs from one-sided valid");
        for (int i = 0; i < 18; i++) drive(1, 1, rnd16(), rnd16(), rnd16(), rnd16());
        drain_check();

        // R5: floor rounding of small negative values.
        tag = "R5";
        clear_coefs();
        load(0, 0, 1, 0);
        drive(1, 1, -3, 5, 0, 0);
        drive(1, 1, 7, -1, 0, 0);
        drive(1, 1, -32768, 32767, 0, 0);
        drain_check();

        // R6: saturation in both directions with all taps at full scale.
        tag = "R6";
        for (int k = 0; k < T; k++) load(0, k, 32767, 0);
        for (int k = 0; k < T; k++) load(1, k, 0, 32767);
        for (int i = 0; i < T + 2; i++) drive(1, 1, 32767, 32767, 32767, -32768);
        for (int i = 0; i < T + 2; i++) drive(1, 1, -32768, -32768, -32768, 32767);
        drain_check();

        // R3 R4 R5 R6: random coefficients on every tap, random valid gaps.
        tag = "R4";
        for (int f = 0; f < 2; f++)
            for (int k = 0; k < T; k++) load(f, k, rnd16() / 4, rnd16() / 4);
        for (int i = 0; i < 600; i++) begin
            int m = $urandom_range(0, 9);
            drive(m != 0, m != 1, rnd16(), rnd16(), rnd16(), rnd16());
        end
        drain_check();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule